// File: doc/BRIEF.md
# Register-Shifted Inverting ALU Slice

This block is the datapath of one data-processing operation. A 32-bit source operand is shifted by a distance held in the low byte of a second register. The shifted value is then bitwise inverted and offered as the destination result. The shift distance may be anywhere from 0 to 255, so distances of a full word or more are ordinary inputs and have defined results.

When the caller asks for it, the block also produces new negative, zero and carry flags. The carry comes from the last bit that leaves the shifter, and the overflow flag always passes through untouched. A condition-passed input gates both the register write and the flag update. A separate output flags any instruction that names the reserved register index, which is 15 by default.

The register file, condition evaluation and instruction decode sit in the surrounding pipeline. An optional output register stage is enabled by default, which gives the block one clock of latency.

Top module: `rss_inv_slice`

## Requirements
- R1: `shift_kind` selects the shift: 0 shifts left with zero fill, 1 shifts right with zero fill, 2 shifts right with sign fill, and 3 rotates right. The distance is the unsigned value of `amt_byte` (0 to 255). `result` is the bitwise inverse of the shifted operand.
- R2: For the left and right logical shifts, a distance of exactly 32 gives a zero shifted value. Its carry is operand bit 0 for a left shift and operand bit 31 for a right shift. Any distance above 32 gives a zero shifted value with carry 0.
- R3: For the sign-filling right shift, a distance of 32 or more gives a shifted value with every bit equal to operand bit 31, and the carry also equals operand bit 31.
- R4: A rotate by a nonzero distance turns the operand right by the distance modulo 32. Its carry is bit 31 of the rotated value, and this also holds when the distance is a nonzero multiple of 32.
- R5: A distance of 0 leaves the operand unshifted for all four kinds, so `result` equals the inverted operand, and the shifter carry equals the incoming C flag.
- R6: `flags_in` and `flags_out` are packed with N in bit 3, Z in bit 2, C in bit 1 and V in bit 0. When both `cond_ok` and `set_flags` are 1, N becomes result bit 31, Z becomes 1 exactly when the result is all zeros, and C becomes the shifter carry.
- R7: The V bit of `flags_out` always equals the V bit of `flags_in`.
- R8: When `cond_ok` is 0, `wr_en` is 0 and `flags_out` equals `flags_in`. When `set_flags` is 0, `flags_out` equals `flags_in`. `wr_en` equals `cond_ok`.
- R9: `unpred` is 1 exactly when at least one of `rd_idx`, `rm_idx` or `rs_idx` equals 15.
- R10: With the default output register, every output follows its inputs one clock later, and an active-low reset clears all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| operand | input | 32 | Value to shift and invert |
| amt_byte | input | 8 | Low byte of the shift-distance register |
| shift_kind | input | 2 | Shift type: 0 left, 1 right logical, 2 right arithmetic, 3 rotate |
| set_flags | input | 1 | Request a flag update |
| cond_ok | input | 1 | Condition passed; gates the write and the flags |
| flags_in | input | 4 | Incoming {N,Z,C,V} |
| rd_idx | input | 4 | Destination register index |
| rm_idx | input | 4 | Operand register index |
| rs_idx | input | 4 | Shift-distance register index |
| result | output | 32 | Inverted shifted value |
| wr_en | output | 1 | Destination write enable |
| flags_out | output | 4 | Outgoing {N,Z,C,V} |
| unpred | output | 1 | A register index equals the reserved value |

## Verification
The errors most likely to hide are at the distance boundaries of 0, 31, 32, 33 and 255, and in rotations by multiples of 32. There a wrong shifter branch corrupts only the carry, or only a handful of result bits, one clock later. For that reason every shift kind is swept across all 256 distances and checked against a reference model that shifts one bit at a time. A stale or wrong flag path shows up on `flags_out` on the very next cycle, usually as a changed V bit or as flags that move while `cond_ok` is low. Each such error is therefore caught on the first instruction that touches it.

// File: rtl/rss_pkg.sv
package rss_pkg;
   typedef enum logic [1:0] {
      SH_LSL = 2'd0,
      SH_LSR = 2'd1,
      SH_ASR = 2'd2,
      SH_ROR = 2'd3
   } shift_e;

   localparam int FLG_N = 3;
   localparam int FLG_Z = 2;
   localparam int FLG_C = 1;
   localparam int FLG_V = 0;
   localparam int FLG_W = 4;
endpackage

// File: rtl/rss_shifter.sv
module rss_shifter #(
   parameter int DATA_W = 32,
   parameter int AMT_W  = 8
) (
   input  logic [DATA_W-1:0] op,
   input  logic [AMT_W-1:0]  amt,
   input  logic [1:0]        kind,
   input  logic              c_in,
   output logic [DATA_W-1:0] shifted,
   output logic              c_out
);
   localparam int SH_W = $clog2(DATA_W);

   if (DATA_W != (1 << SH_W)) begin : g_bad_width
      $error("rss_shifter: DATA_W must be a power of two");
   end
   if (AMT_W <= SH_W) begin : g_bad_amt
      $error("rss_shifter: AMT_W must reach past DATA_W");
   end

   logic [DATA_W:0]     lsl_ext, lsr_ext, asr_ext;
   logic [2*DATA_W-1:0] ror_dbl;
   logic [SH_W-1:0]     rot;
   logic                amt_zero;

   assign amt_zero = (amt == '0);
   assign rot      = amt[SH_W-1:0];
   assign lsl_ext  = {1'b0, op} << amt;
   assign lsr_ext  = {op, 1'b0} >> amt;
   assign asr_ext  = $unsigned($signed({op, 1'b0}) >>> amt);
   assign ror_dbl  = {op, op} >> rot;

   always_comb begin
      shifted = op;
      c_out   = c_in;
      if (!amt_zero) begin
         unique case (rss_pkg::shift_e'(kind))
            rss_pkg::SH_LSL: begin
               shifted = lsl_ext[DATA_W-1:0];
               c_out   = lsl_ext[DATA_W];
            end
            rss_pkg::SH_LSR: begin
               shifted = lsr_ext[DATA_W:1];
               c_out   = lsr_ext[0];
            end
            rss_pkg::SH_ASR: begin
               shifted = asr_ext[DATA_W:1];
               c_out   = asr_ext[0];
            end
            default: begin
               shifted = ror_dbl[DATA_W-1:0];
               c_out   = ror_dbl[DATA_W-1];
            end
         endcase
      end
   end
endmodule

// File: rtl/rss_flag_unit.sv
module rss_flag_unit #(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0]            res,
   input  logic                         sh_carry,
   input  logic                         cond_ok,
   input  logic                         set_flags,
   input  logic [rss_pkg::FLG_W-1:0]    flags_in,
   output logic [rss_pkg::FLG_W-1:0]    flags_nx,
   output logic                         wr_nx
);
   logic upd;

   assign upd   = cond_ok & set_flags;
   assign wr_nx = cond_ok;

   always_comb begin
      flags_nx = flags_in;
      if (upd) begin
         flags_nx[rss_pkg::FLG_N] = res[DATA_W-1];
         flags_nx[rss_pkg::FLG_Z] = ~|res;
         flags_nx[rss_pkg::FLG_C] = sh_carry;
      end
   end
endmodule

// File: rtl/rss_idx_guard.sv
module rss_idx_guard #(
   parameter int IDX_W   = 4,
   parameter int N_IDX   = 3,
   parameter int RSV_IDX = 15
) (
   input  logic [N_IDX*IDX_W-1:0] idx_bus,
   output logic                   hit
);
   localparam logic [IDX_W-1:0] RSV_V = IDX_W'(RSV_IDX);

   if (RSV_IDX >= (1 << IDX_W)) begin : g_bad_rsv
      $error("rss_idx_guard: RSV_IDX does not fit in IDX_W");
   end

   logic [N_IDX-1:0] hits;

   for (genvar i = 0; i < N_IDX; i++) begin : g_cmp
      assign hits[i] = (idx_bus[i*IDX_W +: IDX_W] == RSV_V);
   end

   assign hit = |hits;
endmodule

// File: rtl/rss_out_stage.sv
module rss_out_stage #(
   parameter int W       = 38,
   parameter bit OUT_REG = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q <= '0;
         else        q <= d;
      end
   end else begin : g_wire
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign q = d;
   end
endmodule

// File: rtl/rss_inv_slice.sv
module rss_inv_slice #(
   parameter int DATA_W  = 32,
   parameter int AMT_W   = 8,
   parameter int IDX_W   = 4,
   parameter int RSV_IDX = 15,
   parameter bit OUT_REG = 1'b1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [DATA_W-1:0]            operand,
   input  logic [AMT_W-1:0]             amt_byte,
   input  logic [1:0]                   shift_kind,
   input  logic                         set_flags,
   input  logic                         cond_ok,
   input  logic [rss_pkg::FLG_W-1:0]    flags_in,
   input  logic [IDX_W-1:0]             rd_idx,
   input  logic [IDX_W-1:0]             rm_idx,
   input  logic [IDX_W-1:0]             rs_idx,
   output logic [DATA_W-1:0]            result,
   output logic                         wr_en,
   output logic [rss_pkg::FLG_W-1:0]    flags_out,
   output logic                         unpred
);
   localparam int PK_W = DATA_W + rss_pkg::FLG_W + 2;

   logic [DATA_W-1:0]         shifted, res_nx;
   logic                      sh_c, wr_nx, unp_nx;
   logic [rss_pkg::FLG_W-1:0] flags_nx;
   logic [PK_W-1:0]           pk_d, pk_q;

   rss_shifter #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_shift (
      .op(operand), .amt(amt_byte), .kind(shift_kind),
      .c_in(flags_in[rss_pkg::FLG_C]), .shifted(shifted), .c_out(sh_c)
   );

   assign res_nx = ~shifted;

   rss_flag_unit #(.DATA_W(DATA_W)) u_flags (
      .res(res_nx), .sh_carry(sh_c), .cond_ok(cond_ok),
      .set_flags(set_flags), .flags_in(flags_in),
      .flags_nx(flags_nx), .wr_nx(wr_nx)
   );

   rss_idx_guard #(.IDX_W(IDX_W), .N_IDX(3), .RSV_IDX(RSV_IDX)) u_guard (
      .idx_bus({rs_idx, rm_idx, rd_idx}), .hit(unp_nx)
   );

   assign pk_d = {res_nx, flags_nx, wr_nx, unp_nx};

   rss_out_stage #(.W(PK_W), .OUT_REG(OUT_REG)) u_out (
      .clk(clk), .rst_n(rst_n), .d(pk_d), .q(pk_q)
   );

   assign {result, flags_out, wr_en, unpred} = pk_q;
endmodule

// File: rtl/rss_inv_slice_chk.sv
module rss_inv_slice_chk #(
   parameter int DATA_W  = 32,
   parameter int AMT_W   = 8,
   parameter int IDX_W   = 4,
   parameter int RSV_IDX = 15,
   parameter bit OUT_REG = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [DATA_W-1:0] operand,
   input logic [AMT_W-1:0]  amt_byte,
   input logic              set_flags,
   input logic              cond_ok,
   input logic [3:0]        flags_in,
   input logic [IDX_W-1:0]  rd_idx,
   input logic [IDX_W-1:0]  rm_idx,
   input logic [IDX_W-1:0]  rs_idx,
   input logic [DATA_W-1:0] result,
   input logic              wr_en,
   input logic [3:0]        flags_out,
   input logic              unpred
);
   localparam logic [IDX_W-1:0] RSV_V = IDX_W'(RSV_IDX);

   logic idx_rsv;
   assign idx_rsv = (rd_idx == RSV_V) || (rm_idx == RSV_V) || (rs_idx == RSV_V);

   if (OUT_REG) begin : g_seq
      AST_V_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
         1'b1 |=> flags_out[0] == $past(flags_in[0])); // R7
      AST_HOLD_ON_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
         !cond_ok |=> (!wr_en && flags_out == $past(flags_in))); // R8
      AST_NO_SET_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
         !set_flags |=> flags_out == $past(flags_in)); // R8
      AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
         (cond_ok && set_flags) |=> flags_out[2] == (result == '0)); // R6
      AST_NEG_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
         (cond_ok && set_flags) |=> flags_out[3] == result[DATA_W-1]); // R6
      AST_ZERO_AMT: assert property (@(posedge clk) disable iff (!rst_n)
         (amt_byte == '0) |=> result == ~$past(operand)); // R5
      AST_ZERO_AMT_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
         (cond_ok && set_flags && amt_byte == '0) |=> flags_out[1] == $past(flags_in[1])); // R5
      AST_UNPRED_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
         1'b1 |=> unpred == $past(idx_rsv)); // R9
   end else begin : g_comb
      always_comb begin
         if (rst_n) begin
            AST_V_PASSTHRU: assert (flags_out[0] == flags_in[0]); // R7
            AST_UNPRED_FLAG: assert (unpred == idx_rsv); // R9
            AST_HOLD_ON_FAIL: assert (cond_ok || (!wr_en && flags_out == flags_in)); // R8
            AST_ZERO_AMT: assert (amt_byte != '0 || result == ~operand); // R5
         end
      end
   end
endmodule

bind rss_inv_slice rss_inv_slice_chk #(
   .DATA_W(DATA_W), .AMT_W(AMT_W), .IDX_W(IDX_W),
   .RSV_IDX(RSV_IDX), .OUT_REG(OUT_REG)
) u_chk (
   .clk(clk), .rst_n(rst_n), .operand(operand), .amt_byte(amt_byte),
   .set_flags(set_flags), .cond_ok(cond_ok), .flags_in(flags_in),
   .rd_idx(rd_idx), .rm_idx(rm_idx), .rs_idx(rs_idx),
   .result(result), .wr_en(wr_en), .flags_out(flags_out), .unpred(unpred)
);

// File: tb/tb_rss_inv_slice.sv
module tb_rss_inv_slice;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] operand = '0;
   logic [7:0]  amt_byte = '0;
   logic [1:0]  shift_kind = '0;
   logic        set_flags = 1'b0, cond_ok = 1'b0;
   logic [3:0]  flags_in = '0;
   logic [3:0]  rd_idx = 4'd1, rm_idx = 4'd2, rs_idx = 4'd3;
   logic [31:0] result;
   logic        wr_en, unpred;
   logic [3:0]  flags_out;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   rss_inv_slice dut (
      .clk(clk), .rst_n(rst_n), .operand(operand), .amt_byte(amt_byte),
      .shift_kind(shift_kind), .set_flags(set_flags), .cond_ok(cond_ok),
      .flags_in(flags_in), .rd_idx(rd_idx), .rm_idx(rm_idx), .rs_idx(rs_idx),
      .result(result), .wr_en(wr_en), .flags_out(flags_out), .unpred(unpred)
   );

   // Reference: one bit at a time, returns {carry, value}
   function automatic logic [32:0] ref_shift(logic [31:0] v_in, int amt, int kind, logic c_in);
      logic [31:0] v = v_in;
      logic        c = c_in;
      for (int i = 0; i < amt; i++) begin
         case (kind)
            0: begin c = v[31]; v = {v[30:0], 1'b0}; end
            1: begin c = v[0];  v = {1'b0, v[31:1]}; end
            2: begin c = v[0];  v = {v[31], v[31:1]}; end
            default: begin c = v[0]; v = {v[0], v[31:1]}; end
         endcase
      end
      return {c, v};
   endfunction

   task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic apply(logic [31:0] op, int amt, int kind, logic sf, logic co,
                        logic [3:0] fin, logic [3:0] d, logic [3:0] m, logic [3:0] s,
                        string tag);
      logic [32:0] r;
      logic [31:0] exp_res;
      logic [3:0]  exp_fl;
      @(negedge clk);
      operand = op; amt_byte = 8'(amt); shift_kind = 2'(kind);
      set_flags = sf; cond_ok = co; flags_in = fin;
      rd_idx = d; rm_idx = m; rs_idx = s;
      r = ref_shift(op, amt, kind, fin[1]);
      exp_res = ~r[31:0];
      exp_fl = fin;
      if (sf && co) exp_fl = {exp_res[31], exp_res == 32'd0, r[32], fin[0]};
      @(negedge clk);
      check({tag, " result"}, 64'(result), 64'(exp_res));
      check({tag, " flags R6 R7 R8"}, 64'(flags_out), 64'(exp_fl));
      check({tag, " wr_en R8"}, 64'(wr_en), 64'(co));
      check({tag, " unpred R9"}, 64'(unpred), 64'(d == 4'd15 || m == 4'd15 || s == 4'd15));
   endtask

   initial begin
      #400000;
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      // R10: reset clears outputs
      check("R10 reset result", 64'(result), 64'd0);
      check("R10 reset misc", 64'({wr_en, flags_out, unpred}), 64'd0);
      rst_n = 1'b1;

      // R1 R2 R3 R4 R5: full distance sweep for every kind
      for (int k = 0; k < 4; k++) begin
         for (int a = 0; a < 256; a++) begin
            apply($urandom(), a, k, 1'b1, 1'b1, 4'($urandom()), 4'd1, 4'd2, 4'd3, "R1 sweep");
         end
      end
      // Directed boundaries
      apply(32'h0000_0001, 32, 0, 1'b1, 1'b1, 4'b0000, 1, 2, 3, "R2 lsl32");
      apply(32'h8000_0000, 32, 1, 1'b1, 1'b1, 4'b0000, 1, 2, 3, "R2 lsr32");
      apply(32'hFFFF_FFFF, 33, 0, 1'b1, 1'b1, 4'b0010, 1, 2, 3, "R2 lsl33");
      apply(32'h8000_0001, 200, 2, 1'b1, 1'b1, 4'b0000, 1, 2, 3, "R3 asr200");
      apply(32'h7FFF_FFFE, 32, 2, 1'b1, 1'b1, 4'b0010, 1, 2, 3, "R3 asr32");
      apply(32'h8000_0000, 64, 3, 1'b1, 1'b1, 4'b0000, 1, 2, 3, "R4 ror64");
      apply(32'h1234_5678, 36, 3, 1'b1, 1'b1, 4'b0000, 1, 2, 3, "R4 ror36");
      apply(32'hFFFF_FFFF, 0, 3, 1'b1, 1'b1, 4'b0011, 1, 2, 3, "R5 zero amt");
      apply(32'h0000_0000, 0, 0, 1'b1, 1'b1, 4'b1101, 1, 2, 3, "R5 zero amt c0");
      // R8: condition failed and no set request
      apply(32'h0F0F_0F0F, 4, 1, 1'b1, 1'b0, 4'b1011, 1, 2, 3, "R8 cond fail");
      apply(32'h0F0F_0F0F, 40, 0, 1'b0, 1'b1, 4'b0101, 1, 2, 3, "R8 no set");
      // R9: reserved index in each slot
      apply(32'h1, 1, 0, 1'b0, 1'b1, 4'b0, 15, 2, 3, "R9 rd");
      apply(32'h1, 1, 0, 1'b0, 1'b1, 4'b0, 1, 15, 3, "R9 rm");
      apply(32'h1, 1, 0, 1'b0, 1'b1, 4'b0, 1, 2, 15, "R9 rs");
      apply(32'h1, 1, 0, 1'b0, 1'b1, 4'b0, 14, 14, 14, "R9 none");
      // Random mix, R7 on V passthrough among the checks
      for (int i = 0; i < 1500; i++) begin
         apply($urandom(), int'($urandom_range(0, 255)), int'($urandom_range(0, 3)),
               1'($urandom()), 1'($urandom()), 4'($urandom()),
               4'($urandom()), 4'($urandom()), 4'($urandom()), "R7 random");
      end
      // R10: reset mid-run clears outputs again
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      check("R10 async reset", 64'({result, wr_en, flags_out, unpred}), 64'd0);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule